// File: doc/BRIEF.md
# Debug-Aware Trap Entry Controller

This block sits next to a small in-order core and decides where execution goes whenever the core reports a trap. It also owns the core's current privilege level. A breakpoint trap can divert the core into debug mode. That happens only when the breakpoint-enable bit for the privilege level the core is running at is set. On debug entry the block saves the PC and the privilege, switches to machine privilege and redirects to a fixed debug ROM start address. After a debug cause has been latched, any later trap that does not itself enter debug goes to a fixed debug exception address. Such a trap leaves the machine trap registers untouched. With no debug cause latched, traps follow the ordinary machine path: the PC goes to the trap vector, the exception PC and cause are recorded, and privilege becomes M.

The block holds three debug registers: the debug control/status word, the debug PC and a debug scratch word. All three are reached through a small select-and-write port with a combinational read. The core can also request a privilege change directly. Any privilege write pulses a TLB flush for one cycle. The halt bit is preloaded from a halt-on-reset input, but only during the first reset after power-up.

Top module: `dbg_trap_ctrl`

## Requirements
- R1: A trap with `trap_is_bkpt_i` set enters debug mode only when the enable bit for the current `priv_o` is set. The enable bits sit at control bit 7+p for privilege code p, with U=0, S=1, H=2, M=3.
- R2: One cycle after debug entry:
  - `redirect_pc_o` equals `DBG_ROM_START`.
  - `priv_o` is 3.
  - The cause field (control bits 5:3) reads 1.
  - The saved-privilege field (bits 1:0) holds the former privilege.
  - The debug PC (select 1) holds `cur_pc_i` from the trap cycle.
- R3: While the cause field is nonzero, a trap that does not enter debug redirects to `DBG_ROM_EXC`. `mcause_o`, `mepc_o` and `priv_o` stay unchanged, and no flush is raised.
- R4: While the cause field is zero, a trap that does not enter debug has these effects one cycle later:
  - It redirects to `mtvec_i`.
  - `mepc_o` takes `trap_epc_i` and `mcause_o` takes `trap_cause_i`.
  - `priv_o` becomes 3.
- R5: Each reset cycle before the first cycle out of reset loads the halt bit (control bit 6) from `halt_on_reset_i`. Every later reset clears the halt bit, whatever that input is.
- R6: A privilege request without a trap sets `priv_o` one cycle later. A request for code 2 (H) yields 0 (U), so `priv_o` never reads 2.
- R7: `tlb_flush_o` is high for exactly the cycle after every privilege write (debug entry, machine trap, request) and low otherwise.
- R8: A control read (select 0) returns the following fields:
  - The version (bits 31:28) reads 1.
  - Bits 27:12 read zero.
  - The live `dbg_int_i` appears at bit 11.
  - The stored fields occupy their listed positions: halt at bit 6, step at bit 2.
- R9: A control write updates only the saved privilege, step, the four enables and halt. Writing ones to bits 5:3 leaves the cause field unchanged.
- R10: Select 1 reads and writes the debug PC and select 2 the scratch word. Select 3 reads zero and writes nothing.
- R11: A trap takes precedence over a privilege request in the same cycle. Debug entry takes precedence over a same-cycle control or debug-PC write for the fields it sets.
- R12: After reset the outputs are as follows:
  - `priv_o` is 3.
  - Redirect, flush, `mcause_o` and `mepc_o` are zero.
  - All control fields except halt, the debug PC and the scratch word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt_on_reset_i | input | 1 | Halt request applied by the first reset |
| dbg_int_i | input | 1 | Live debug interrupt, shown in control reads |
| trap_valid_i | input | 1 | A trap is taken this cycle |
| trap_is_bkpt_i | input | 1 | The trap is a breakpoint |
| trap_cause_i | input | XLEN | Trap cause code |
| trap_epc_i | input | XLEN | Exception PC for the machine path |
| cur_pc_i | input | XLEN | Current PC, saved on debug entry |
| mtvec_i | input | XLEN | Machine trap vector |
| priv_req_valid_i | input | 1 | Privilege change request |
| priv_req_i | input | 2 | Requested privilege |
| csr_we_i | input | 1 | Debug register write strobe |
| csr_sel_i | input | 2 | 0 control, 1 debug PC, 2 scratch |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data |
| redirect_valid_o | output | 1 | Redirect issued, one cycle after a trap |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege |
| tlb_flush_o | output | 1 | One-cycle TLB flush pulse |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC register |

## Verification
Every registered result is due one cycle after its stimulus: redirect, privilege, flush, the machine registers and the debug register contents. `csr_rdata_o` is combinational on that registered state together with the current select and `dbg_int_i`. The bench drives inputs one time unit after a rising edge. At each edge it advances its own model, using the inputs that were present at that edge. One time unit later it compares every output against the model, including the read data for the select it is still holding. Directed sequences cover each privilege's enable bit, debug entry, the exception redirect, collisions and both reset cases. Seeded random traffic covers the rest.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_H = 2'd2;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int          CTRL_W      = 32;
  localparam int          NPRIV       = 4;
  localparam logic [2:0]  CAUSE_SWBP  = 3'd1;
  localparam logic [3:0]  CTRL_VER    = 4'd1;

  localparam logic [1:0]  SEL_CTRL    = 2'd0;
  localparam logic [1:0]  SEL_DPC     = 2'd1;
  localparam logic [1:0]  SEL_SCRATCH = 2'd2;

  typedef struct packed {
    logic [NPRIV-1:0] brk_en;
    logic             halt;
    logic [2:0]       cause;
    logic             step;
    logic [1:0]       saved_priv;
  } dctrl_t;

  function automatic logic [1:0] fold_priv(input logic [1:0] p);
    return (p == PRIV_H) ? PRIV_U : p;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input dctrl_t c, input logic dint);
    logic [CTRL_W-1:0] w;
    w        = '0;
    w[31:28] = CTRL_VER;
    w[11]    = dint;
    w[10:7]  = c.brk_en;
    w[6]     = c.halt;
    w[5:3]   = c.cause;
    w[2]     = c.step;
    w[1:0]   = c.saved_priv;
    return w;
  endfunction

  function automatic dctrl_t apply_ctrl_write(input dctrl_t c, input logic [CTRL_W-1:0] w);
    dctrl_t n;
    n            = c;
    n.saved_priv = w[1:0];
    n.step       = w[2];
    n.halt       = w[6];
    n.brk_en     = w[10:7];
    return n;
  endfunction

endpackage

// File: rtl/dbg_trap_router.sv
module dbg_trap_router
  import dbg_trap_pkg::*;
#(
  parameter int               XLEN          = 32,
  parameter logic [XLEN-1:0]  DBG_ROM_START = 'h800,
  parameter logic [XLEN-1:0]  DBG_ROM_EXC   = 'h808
) (
  input  logic             trap_valid_i,
  input  logic             trap_is_bkpt_i,
  input  logic [1:0]       priv_i,
  input  logic [NPRIV-1:0] brk_en_i,
  input  logic             cause_set_i,
  input  logic [XLEN-1:0]  mtvec_i,
  output logic             enter_dbg_o,
  output logic             dbg_exc_o,
  output logic             m_trap_o,
  output logic [XLEN-1:0]  target_o
);

  logic brk_allowed;

  always_comb begin
    brk_allowed = brk_en_i[priv_i];
    enter_dbg_o = trap_valid_i && trap_is_bkpt_i && brk_allowed;
    dbg_exc_o   = trap_valid_i && !enter_dbg_o && cause_set_i;
    m_trap_o    = trap_valid_i && !enter_dbg_o && !cause_set_i;
    if (enter_dbg_o)    target_o = DBG_ROM_START;
    else if (dbg_exc_o) target_o = DBG_ROM_EXC;
    else                target_o = mtvec_i;
  end

endmodule

// File: rtl/dbg_priv_tracker.sv
module dbg_priv_tracker
  import dbg_trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       force_m_i,
  input  logic       req_valid_i,
  input  logic [1:0] req_priv_i,
  output logic [1:0] priv_o,
  output logic       flush_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_o  <= PRIV_M;
      flush_o <= 1'b0;
    end else begin
      flush_o <= force_m_i || req_valid_i;
      if (force_m_i)        priv_o <= PRIV_M;
      else if (req_valid_i) priv_o <= fold_priv(req_priv_i);
    end
  end

  p_no_h_level_r6: assert property (@(posedge clk) disable iff (rst)
    priv_o != PRIV_H);

  p_flush_on_change_r7: assert property (@(posedge clk) disable iff (rst)
    (priv_o != $past(priv_o)) |-> flush_o);

  p_force_m_r2: assert property (@(posedge clk) disable iff (rst)
    force_m_i |=> (priv_o == PRIV_M) && flush_o);

endmodule

// File: rtl/dbg_csr_file.sv
module dbg_csr_file
  import dbg_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_on_reset_i,
  input  logic             dbg_int_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             enter_dbg_i,
  input  logic [1:0]       cur_priv_i,
  input  logic [XLEN-1:0]  cur_pc_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic [NPRIV-1:0] brk_en_o,
  output logic             cause_set_o
);

  dctrl_t          ctrl_q;
  dctrl_t          ctrl_wr;
  logic [XLEN-1:0] dpc_q;
  logic [XLEN-1:0] scratch_q;
  bit              hor_spent;

  always_comb begin
    ctrl_wr = ctrl_q;
    if (we_i && sel_i == SEL_CTRL)
      ctrl_wr = apply_ctrl_write(ctrl_q, wdata_i[CTRL_W-1:0]);
    if (enter_dbg_i) begin
      ctrl_wr.cause      = CAUSE_SWBP;
      ctrl_wr.saved_priv = cur_priv_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) hor_spent <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      ctrl_q.halt <= halt_on_reset_i && !hor_spent;
      dpc_q       <= '0;
      scratch_q   <= '0;
    end else begin
      ctrl_q <= ctrl_wr;
      if (enter_dbg_i)                     dpc_q     <= cur_pc_i;
      else if (we_i && sel_i == SEL_DPC)   dpc_q     <= wdata_i;
      if (we_i && sel_i == SEL_SCRATCH)    scratch_q <= wdata_i;
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CTRL:    rdata_o = XLEN'(pack_ctrl(ctrl_q, dbg_int_i));
      SEL_DPC:     rdata_o = dpc_q;
      SEL_SCRATCH: rdata_o = scratch_q;
      default:     rdata_o = '0;
    endcase
  end

  assign brk_en_o    = ctrl_q.brk_en;
  assign cause_set_o = (ctrl_q.cause != 3'd0);

  p_cause_locked_r9: assert property (@(posedge clk) disable iff (rst)
    !enter_dbg_i |=> $stable(ctrl_q.cause));

  p_dpc_capture_r2: assert property (@(posedge clk) disable iff (rst)
    enter_dbg_i |=> (dpc_q == $past(cur_pc_i)) && (ctrl_q.cause == CAUSE_SWBP));

  p_saved_priv_r11: assert property (@(posedge clk) disable iff (rst)
    enter_dbg_i |=> ctrl_q.saved_priv == $past(cur_priv_i));

endmodule

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl
  import dbg_trap_pkg::*;
#(
  parameter int               XLEN          = 32,
  parameter logic [XLEN-1:0]  DBG_ROM_START = 'h800,
  parameter logic [XLEN-1:0]  DBG_ROM_EXC   = 'h808
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_on_reset_i,
  input  logic            dbg_int_i,
  input  logic            trap_valid_i,
  input  logic            trap_is_bkpt_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_epc_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic            priv_req_valid_i,
  input  logic [1:0]      priv_req_i,
  input  logic            csr_we_i,
  input  logic [1:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o,
  output logic            tlb_flush_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o
);

  logic             enter_dbg;
  logic             dbg_exc;
  logic             m_trap;
  logic [XLEN-1:0]  target_pc;
  logic [NPRIV-1:0] brk_en;
  logic             cause_set;
  logic             req_accept;

  assign req_accept = priv_req_valid_i && !trap_valid_i;

  dbg_trap_router #(
    .XLEN(XLEN), .DBG_ROM_START(DBG_ROM_START), .DBG_ROM_EXC(DBG_ROM_EXC)
  ) u_router (
    .trap_valid_i  (trap_valid_i),
    .trap_is_bkpt_i(trap_is_bkpt_i),
    .priv_i        (priv_o),
    .brk_en_i      (brk_en),
    .cause_set_i   (cause_set),
    .mtvec_i       (mtvec_i),
    .enter_dbg_o   (enter_dbg),
    .dbg_exc_o     (dbg_exc),
    .m_trap_o      (m_trap),
    .target_o      (target_pc)
  );

  dbg_priv_tracker u_priv (
    .clk        (clk),
    .rst        (rst),
    .force_m_i  (enter_dbg || m_trap),
    .req_valid_i(req_accept),
    .req_priv_i (priv_req_i),
    .priv_o     (priv_o),
    .flush_o    (tlb_flush_o)
  );

  dbg_csr_file #(.XLEN(XLEN)) u_csr (
    .clk            (clk),
    .rst            (rst),
    .halt_on_reset_i(halt_on_reset_i),
    .dbg_int_i      (dbg_int_i),
    .we_i           (csr_we_i),
    .sel_i          (csr_sel_i),
    .wdata_i        (csr_wdata_i),
    .enter_dbg_i    (enter_dbg),
    .cur_priv_i     (priv_o),
    .cur_pc_i       (cur_pc_i),
    .rdata_o        (csr_rdata_o),
    .brk_en_o       (brk_en),
    .cause_set_o    (cause_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      mcause_o         <= '0;
      mepc_o           <= '0;
    end else begin
      redirect_valid_o <= trap_valid_i;
      if (trap_valid_i) redirect_pc_o <= target_pc;
      if (m_trap) begin
        mcause_o <= trap_cause_i;
        mepc_o   <= trap_epc_i;
      end
    end
  end

  p_dbg_vector_r2: assert property (@(posedge clk) disable iff (rst)
    enter_dbg |=> redirect_valid_o && (redirect_pc_o == DBG_ROM_START) && (priv_o == PRIV_M));

  p_exc_keeps_mregs_r3: assert property (@(posedge clk) disable iff (rst)
    dbg_exc |=> $stable(mcause_o) && $stable(mepc_o) && (redirect_pc_o == DBG_ROM_EXC) && !tlb_flush_o);

  p_mtrap_regs_r4: assert property (@(posedge clk) disable iff (rst)
    m_trap |=> (mepc_o == $past(trap_epc_i)) && (mcause_o == $past(trap_cause_i)));

  p_trap_beats_req_r11: assert property (@(posedge clk) disable iff (rst)
    (trap_valid_i && !enter_dbg && !m_trap) |=> $stable(priv_o));

endmodule

// File: tb/dbg_trap_ctrl_tb.sv
module dbg_trap_ctrl_tb;
  localparam int          XLEN  = 32;
  localparam logic [31:0] START = 32'h0000_0800;
  localparam logic [31:0] EXCA  = 32'h0000_0808;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hor = 1'b0, dint = 1'b0;
  logic tv = 1'b0, bk = 1'b0;
  logic [31:0] tcause = '0, tepc = '0, cpc = '0, mtvec = '0;
  logic preq = 1'b0;
  logic [1:0] ppriv = '0;
  logic we = 1'b0;
  logic [1:0] sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rpc, mcause, mepc;
  logic rv, flush;
  logic [1:0] priv;

  always #2 clk = ~clk;

  dbg_trap_ctrl #(.XLEN(XLEN), .DBG_ROM_START(START), .DBG_ROM_EXC(EXCA)) u_dut (
    .clk(clk), .rst(rst), .halt_on_reset_i(hor), .dbg_int_i(dint),
    .trap_valid_i(tv), .trap_is_bkpt_i(bk), .trap_cause_i(tcause),
    .trap_epc_i(tepc), .cur_pc_i(cpc), .mtvec_i(mtvec),
    .priv_req_valid_i(preq), .priv_req_i(ppriv),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .redirect_valid_o(rv), .redirect_pc_o(rpc), .priv_o(priv),
    .tlb_flush_o(flush), .mcause_o(mcause), .mepc_o(mepc)
  );

  int n_tests = 0, n_fail = 0;

  // model state
  logic [1:0] m_priv; logic m_flush, m_rv; logic [31:0] m_rpc, m_mcause, m_mepc;
  logic [2:0] m_cause; logic [1:0] m_sprv; logic m_step, m_halt; logic [3:0] m_en;
  logic [31:0] m_dpc, m_scr; bit m_spent;

  function automatic logic [31:0] exp_read(input logic [1:0] s);
    if (s == 2'd0)
      return (32'd1 << 28) | (32'(dint) << 11) | (32'(m_en) << 7) | (32'(m_halt) << 6)
           | (32'(m_cause) << 3) | (32'(m_step) << 2) | 32'(m_sprv);
    else if (s == 2'd1) return m_dpc;
    else if (s == 2'd2) return m_scr;
    return 32'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic enter, exc, mt;
    if (rst) begin
      m_priv = 2'd3; m_flush = 0; m_rv = 0; m_rpc = 0; m_mcause = 0; m_mepc = 0;
      m_cause = 0; m_sprv = 0; m_step = 0; m_en = 0; m_dpc = 0; m_scr = 0;
      m_halt = hor & ~m_spent;
      return;
    end
    m_spent = 1;
    enter = tv && bk && m_en[m_priv];
    exc   = tv && !enter && (m_cause != 0);
    mt    = tv && !enter && (m_cause == 0);
    if (we && sel == 2'd0) begin
      m_sprv = wdata[1:0]; m_step = wdata[2]; m_halt = wdata[6]; m_en = wdata[10:7];
    end
    if (we && sel == 2'd1) m_dpc = wdata;
    if (we && sel == 2'd2) m_scr = wdata;
    if (enter) begin m_cause = 3'd1; m_sprv = m_priv; m_dpc = cpc; end
    m_rv = tv;
    if (enter) m_rpc = START; else if (exc) m_rpc = EXCA; else if (mt) m_rpc = mtvec;
    if (mt) begin m_mcause = tcause; m_mepc = tepc; end
    m_flush = enter || mt || (preq && !tv);
    if (enter || mt) m_priv = 2'd3;
    else if (preq && !tv) m_priv = (ppriv == 2'd2) ? 2'd0 : ppriv;
  endtask

  task automatic check_all();
    chk("R6", "priv", 32'(priv), 32'(m_priv));
    chk("R7", "tlb_flush", 32'(flush), 32'(m_flush));
    chk("R2", "redirect_valid", 32'(rv), 32'(m_rv));
    chk("R3", "redirect_pc", rpc, m_rpc);
    chk("R4", "mcause", mcause, m_mcause);
    chk("R4", "mepc", mepc, m_mepc);
    chk("R8", "csr_rdata", rdata, exp_read(sel));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    check_all();
  endtask

  task automatic idle();
    tv = 0; bk = 0; preq = 0; we = 0;
  endtask

  task automatic rd_sel(input logic [1:0] s, input string req, input logic [31:0] exp);
    sel = s; we = 0; #0.5;
    chk(req, "read", rdata, exp);
  endtask

  task automatic rand_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      tv = ($urandom % 6) == 0; bk = $urandom % 2;
      tcause = $urandom; tepc = $urandom; cpc = $urandom; mtvec = $urandom;
      preq = ($urandom % 5) == 0; ppriv = 2'($urandom);
      we = ($urandom % 5) == 0; sel = 2'($urandom); wdata = $urandom;
      dint = $urandom % 2;
      cyc();
    end
    idle();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_spent = 0;
    // first reset with halt request: R5, R12
    rst = 1; hor = 1; #1;
    cyc(); cyc();
    rst = 0; hor = 0;
    cyc();
    rd_sel(2'd0, "R5", 32'h1000_0040);
    rd_sel(2'd1, "R12", 32'd0);
    chk("R12", "priv after reset", 32'(priv), 32'd3);

    // write all ones to control: cause stays zero (R9)
    we = 1; sel = 2'd0; wdata = 32'hFFFF_FFFF; cyc(); idle();
    rd_sel(2'd0, "R9", 32'h1000_07C7);
    dint = 1; rd_sel(2'd0, "R8", 32'h1000_0FC7); dint = 0;

    // privilege requests, H folds to U (R6)
    preq = 1; ppriv = 2'd2; cyc(); idle();
    chk("R6", "H request maps to U", 32'(priv), 32'd0);
    chk("R7", "flush after request", 32'(flush), 32'd1);
    cyc();
    chk("R7", "flush single pulse", 32'(flush), 32'd0);

    // only S enable set; breakpoint at U goes machine path (R1, R4)
    we = 1; sel = 2'd0; wdata = 32'h0000_0100; cyc(); idle();
    tv = 1; bk = 1; tcause = 32'd3; tepc = 32'h100; cpc = 32'h100; mtvec = 32'h4000; cyc(); idle();
    chk("R1", "bkpt with U disabled to mtvec", rpc, 32'h4000);
    chk("R4", "mepc", mepc, 32'h100);

    // at S, breakpoint enters debug (R1, R2)
    preq = 1; ppriv = 2'd1; cyc(); idle();
    tv = 1; bk = 1; cpc = 32'h2468; tepc = 32'h2468; cyc(); idle();
    chk("R2", "debug entry target", rpc, START);
    chk("R2", "debug entry priv", 32'(priv), 32'd3);
    rd_sel(2'd0, "R2", 32'h1000_0109);
    rd_sel(2'd1, "R2", 32'h2468);

    // cause latched: plain trap goes to exception address (R3)
    tv = 1; bk = 0; tcause = 32'd7; tepc = 32'h9999; mtvec = 32'h5000; cyc(); idle();
    chk("R3", "exc address", rpc, EXCA);
    chk("R3", "mcause kept", mcause, 32'd3);
    chk("R3", "no flush", 32'(flush), 32'd0);

    // trap and request together: trap wins (R11)
    tv = 1; bk = 0; preq = 1; ppriv = 2'd0; cyc(); idle();
    chk("R11", "priv kept", 32'(priv), 32'd3);
    // debug entry collides with dpc write (R11)
    we = 1; sel = 2'd0; wdata = 32'h0000_0400; cyc(); idle();
    tv = 1; bk = 1; cpc = 32'hABC0; we = 1; sel = 2'd1; wdata = 32'h1111; cyc(); idle();
    rd_sel(2'd1, "R11", 32'hABC0);

    // scratch and select 3 (R10)
    we = 1; sel = 2'd2; wdata = 32'hCAFE_F00D; cyc();
    sel = 2'd3; wdata = 32'h1234_5678; cyc(); idle();
    rd_sel(2'd2, "R10", 32'hCAFE_F00D);
    rd_sel(2'd3, "R10", 32'd0);

    rand_cycles(400);

    // second reset: halt request consumed (R5)
    rst = 1; hor = 1; cyc(); cyc();
    rst = 0; hor = 0; cyc();
    rd_sel(2'd0, "R5", 32'h1000_0000);
    rand_cycles(400);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule